// File: doc/BRIEF.md
# Time-of-Day Calendar Counter

This block holds a wall-clock time and calendar as seven byte-wide fields (seconds, minutes, hours, day of week, date, month, two-digit year) and advances them by one second on every pulse of a one-second tick input. The fields are stored and counted directly in the encoding chosen by a mode pin: plain binary or packed BCD. A second mode pin selects a 24-hour or a 12-hour hour field. In 12-hour mode bit 7 of the hour byte is the afternoon flag.

Software loads and reads the fields through a simple register port. A write lands on the next clock edge. A read is combinational from the addressed field. A hold pin stops the counters so that software can load a consistent time without a carry rippling through part of it. Month lengths, leap years and the year wrap are handled inside the block. An optional mode moves the hour forward in spring and back in autumn.

All control and register pins are plain level signals sampled on the rising clock edge. There is no streaming interface, so there is no back-pressure. A tick pulse is consumed in the cycle it is high.

Top module: `tod_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. A write stores the byte unchanged at the next clock edge. The read data shows the addressed field in the same cycle. Address 7 reads 0x00, and writes to it change no field.
- R3: A cycle with the tick high, hold low and no write advances the time by exactly one second. No field changes in a cycle without a tick and without a write.
- R4: With bin_i=1, seconds and minutes count 0x00 to 0x3B. With bin_i=0 they count 0x00 to 0x59 in BCD, and a low digit of 9 carries into the high digit. A field that wraps to 0x00 increments the next field in the same tick.
- R5: With h24_i=1 the hour counts 0 to 23. When the hour wraps from 23 to 0, the calendar advances by one day.
- R6: With h24_i=0 the hour counts 1 to 12, and bit 7 is the afternoon flag. Going from 11 to 12 inverts the flag. Going from 12 to 1 keeps it. Going from 11 with the flag set to 12 with the flag clear advances the day.
- R7: Day of week counts 1 to 7, with Sunday as 1. It advances with every day increment and wraps from 7 to 1.
- R8: Months 4, 6, 9 and 11 have 30 days, and all other months except February have 31. After the last day, the date returns to 1 and the month advances.
- R9: February has 29 days when the year value is divisible by 4, including year 0. Otherwise it has 28.
- R10: After December 31 comes January 1, and the year advances. Year 99 wraps to 0.
- R11: While hold_i is high, ticks change no field. Writes are still stored.
- R12: A tick in the same cycle as a write is dropped. Only the written field changes.
- R13: With dst_en_i=1, a tick at 01:59:59 on a Sunday in April with date 1 to 7 gives 03:00:00. With dst_en_i=0 the same tick gives 02:00:00.
- R14: With dst_en_i=1, the first tick at 01:59:59 on a Sunday in October with date 25 or later gives 01:00:00. Reaching 01:59:59 again that day proceeds to 02:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| hold_i | input | 1 | Freezes counting while high |
| bin_i | input | 1 | 1 for binary fields, 0 for BCD |
| h24_i | input | 1 | 1 for 24-hour hours, 0 for 12-hour with the afternoon flag in bit 7 |
| dst_en_i | input | 1 | Enables the seasonal hour shift |
| wr_en_i | input | 1 | Writes wdata_i to the addressed field |
| addr_i | input | 3 | Field address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Addressed field, combinational |

## Verification
A wrong carry or limit inside a counter shows up as a wrong byte on rdata_o on the clock edge of the tick that crosses the boundary. For that reason the bench loads each field just below a rollover and reads every affected field one cycle after a single tick. Faults in the encoding (a binary limit applied in BCD, or a flipped afternoon flag) appear in the same tick and only at those boundaries. A stale daylight-shift flag is visible only on the second pass through 01:59:59 on an autumn Sunday, so that sequence is run explicitly.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int VAL_W  = 7;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

  // Field byte to numeric value in the active encoding.
  function automatic logic [VAL_W-1:0] fdec(input logic [BYTE_W-1:0] v, input logic bin);
    logic [VAL_W-1:0] t;
    if (bin) t = v[VAL_W-1:0];
    else     t = VAL_W'(v[7:4]) * VAL_W'(10) + VAL_W'(v[3:0]);
    return t;
  endfunction

  // Numeric value to field byte in the active encoding.
  function automatic logic [BYTE_W-1:0] fenc(input logic [VAL_W-1:0] n, input logic bin);
    logic [VAL_W-1:0] tens;
    logic [VAL_W-1:0] ones;
    logic [BYTE_W-1:0] r;
    tens = n / VAL_W'(10);
    ones = n - tens * VAL_W'(10);
    if (bin) r = {1'b0, n};
    else     r = {tens[3:0], ones[3:0]};
    return r;
  endfunction

  function automatic logic [VAL_W-1:0] month_len(input logic [VAL_W-1:0] m, input logic leap);
    logic [VAL_W-1:0] d;
    case (m)
      7'd2:                       d = leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    d = 7'd30;
      default:                    d = 7'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/tod_wrap_unit.sv
module tod_wrap_unit
  import tod_pkg::*;
#(
  parameter int LO = 0
) (
  input  logic [BYTE_W-1:0] cur_i,
  input  logic [VAL_W-1:0]  lim_i,
  input  logic              bin_i,
  input  logic              inc_i,
  output logic [BYTE_W-1:0] nxt_o,
  output logic              carry_o
);
  logic [VAL_W-1:0] val;

  always_comb begin
    val     = fdec(cur_i, bin_i);
    carry_o = inc_i && (val >= lim_i);
    if (!inc_i)       nxt_o = cur_i;
    else if (carry_o) nxt_o = fenc(VAL_W'(LO), bin_i);
    else              nxt_o = fenc(val + VAL_W'(1), bin_i);
  end
endmodule

// File: rtl/tod_hour_unit.sv
module tod_hour_unit
  import tod_pkg::*;
(
  input  logic [BYTE_W-1:0] cur_i,
  input  logic              bin_i,
  input  logic              h24_i,
  input  logic              inc_i,
  output logic [BYTE_W-1:0] nxt_o,
  output logic              carry_o
);
  logic             pm;
  logic [VAL_W-1:0] hv;
  logic [BYTE_W-1:0] enc_t;

  always_comb begin
    pm      = cur_i[7];
    hv      = fdec({1'b0, cur_i[6:0]}, bin_i);
    nxt_o   = cur_i;
    carry_o = 1'b0;
    enc_t   = '0;
    if (inc_i) begin
      if (h24_i) begin
        if (hv >= 7'd23) begin
          nxt_o   = fenc(7'd0, bin_i);
          carry_o = 1'b1;
        end else begin
          nxt_o = fenc(hv + 7'd1, bin_i);
        end
      end else begin
        if (hv == 7'd11) begin
          enc_t   = fenc(7'd12, bin_i);
          nxt_o   = {~pm, enc_t[6:0]};
          carry_o = pm;
        end else if (hv >= 7'd12) begin
          enc_t = fenc(7'd1, bin_i);
          nxt_o = {pm, enc_t[6:0]};
        end else begin
          enc_t = fenc(hv + 7'd1, bin_i);
          nxt_o = {pm, enc_t[6:0]};
        end
      end
    end
  end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic              bin_i,
  input  logic              h24_i,
  input  logic              dst_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, yr_q;
  logic [BYTE_W-1:0] sec_n, min_n, hour_n, dow_n, date_n, mon_n, yr_n;
  logic sec_c, min_c, hour_c, dow_c, date_c, mon_c, yr_c;
  logic fb_done_q;
  logic advance;
  logic [VAL_W-1:0] mon_v, yr_v, date_v, mlen;
  logic at_159, sunday, spring, fall;

  assign advance = tick_i && !hold_i && !wr_en_i;
  assign mon_v   = fdec(mon_q, bin_i);
  assign yr_v    = fdec(yr_q, bin_i);
  assign date_v  = fdec(date_q, bin_i);
  assign mlen    = month_len(mon_v, yr_v[1:0] == 2'b00);

  tod_wrap_unit #(.LO(0)) u_sec (
    .cur_i(sec_q), .lim_i(7'd59), .bin_i(bin_i), .inc_i(advance),
    .nxt_o(sec_n), .carry_o(sec_c));
  tod_wrap_unit #(.LO(0)) u_min (
    .cur_i(min_q), .lim_i(7'd59), .bin_i(bin_i), .inc_i(sec_c),
    .nxt_o(min_n), .carry_o(min_c));
  tod_hour_unit u_hour (
    .cur_i(hour_q), .bin_i(bin_i), .h24_i(h24_i), .inc_i(min_c),
    .nxt_o(hour_n), .carry_o(hour_c));
  tod_wrap_unit #(.LO(1)) u_dow (
    .cur_i(dow_q), .lim_i(7'd7), .bin_i(bin_i), .inc_i(hour_c),
    .nxt_o(dow_n), .carry_o(dow_c));
  tod_wrap_unit #(.LO(1)) u_date (
    .cur_i(date_q), .lim_i(mlen), .bin_i(bin_i), .inc_i(hour_c),
    .nxt_o(date_n), .carry_o(date_c));
  tod_wrap_unit #(.LO(1)) u_mon (
    .cur_i(mon_q), .lim_i(7'd12), .bin_i(bin_i), .inc_i(date_c),
    .nxt_o(mon_n), .carry_o(mon_c));
  tod_wrap_unit #(.LO(0)) u_yr (
    .cur_i(yr_q), .lim_i(7'd99), .bin_i(bin_i), .inc_i(mon_c),
    .nxt_o(yr_n), .carry_o(yr_c));

  // Seasonal shift: the byte 0x01 means 1 o'clock before noon in every mode.
  assign at_159 = min_c && (hour_q == 8'h01);
  assign sunday = (dow_q == 8'h01);
  assign spring = dst_en_i && at_159 && sunday && (mon_v == 7'd4) && (date_v <= 7'd7);
  assign fall   = dst_en_i && at_159 && sunday && (mon_v == 7'd10) && (date_v >= 7'd25)
                  && !fb_done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= 8'h00;
      min_q     <= 8'h00;
      hour_q    <= 8'h00;
      dow_q     <= 8'h01;
      date_q    <= 8'h01;
      mon_q     <= 8'h01;
      yr_q      <= 8'h00;
      fb_done_q <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_SEC:   sec_q  <= wdata_i;
        A_MIN:   min_q  <= wdata_i;
        A_HOUR:  hour_q <= wdata_i;
        A_DOW:   dow_q  <= wdata_i;
        A_DATE:  date_q <= wdata_i;
        A_MON:   mon_q  <= wdata_i;
        A_YEAR:  yr_q   <= wdata_i;
        default: ;
      endcase
    end else begin
      sec_q  <= sec_n;
      min_q  <= min_n;
      hour_q <= spring ? 8'h03 : (fall ? 8'h01 : hour_n);
      dow_q  <= dow_n;
      date_q <= date_n;
      mon_q  <= mon_n;
      yr_q   <= yr_n;
      if (fall)        fb_done_q <= 1'b1;
      else if (hour_c) fb_done_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = sec_q;
      A_MIN:   rdata_o = min_q;
      A_HOUR:  rdata_o = hour_q;
      A_DOW:   rdata_o = dow_q;
      A_DATE:  rdata_o = date_q;
      A_MON:   rdata_o = mon_q;
      A_YEAR:  rdata_o = yr_q;
      default: rdata_o = '0;
    endcase
  end

  logic unused_c;
  assign unused_c = dow_c ^ yr_c;
endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
  import tod_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              hold_i,
  input logic              bin_i,
  input logic              h24_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [BYTE_W-1:0] sec_q,
  input logic [BYTE_W-1:0] min_q,
  input logic [BYTE_W-1:0] hour_q,
  input logic [BYTE_W-1:0] dow_q,
  input logic [BYTE_W-1:0] date_q,
  input logic [BYTE_W-1:0] mon_q,
  input logic [BYTE_W-1:0] yr_q
);
  // R2: a write to the minutes address lands unchanged
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_MIN) |=> (min_q == $past(wdata_i)));

  // R3: no tick and no write keeps every field
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
      $stable(dow_q) && $stable(date_q) && $stable(mon_q) && $stable(yr_q)));

  // R11: hold freezes all fields when nothing is written
  a_r11_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
      $stable(dow_q) && $stable(date_q) && $stable(mon_q) && $stable(yr_q)));

  // R4: seconds at the top of their range return to zero on a tick
  a_r4_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !hold_i && !wr_en_i &&
      ((sec_q == 8'h59 && !bin_i) || (sec_q == 8'h3B && bin_i))) |=> (sec_q == 8'h00));

  // R7: whenever the date moves by counting, the weekday moves too
  a_r7_dow_follows_date: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(date_q) && !$past(wr_en_i)) |-> !$stable(dow_q));

  // R6: the afternoon flag changes by counting only when leaving hour 11
  a_r6_pm_flip_at_11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hour_q[7]) && !$past(wr_en_i) && !$past(h24_i)) |->
      (fdec({1'b0, $past(hour_q[6:0])}, $past(bin_i)) == 7'd11));
endmodule

bind tod_calendar tod_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold_i), .bin_i(bin_i),
  .h24_i(h24_i), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dow_q(dow_q),
  .date_q(date_q), .mon_q(mon_q), .yr_q(yr_q));

// File: tb/tod_calendar_tb_top.sv
module tod_calendar_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, hold = 1'b0, bin = 1'b0, h24 = 1'b1, dst = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tod_calendar dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(hold), .bin_i(bin),
    .h24_i(h24), .dst_en_i(dst), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick1;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  task automatic set_date(input logic [7:0] dw, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
    wr(3'd3, dw); wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
  endtask

  task automatic t_reset;
    rd_chk("R1 sec", 3'd0, 8'h00);  rd_chk("R1 min", 3'd1, 8'h00);
    rd_chk("R1 hour", 3'd2, 8'h00); rd_chk("R1 dow", 3'd3, 8'h01);
    rd_chk("R1 date", 3'd4, 8'h01); rd_chk("R1 mon", 3'd5, 8'h01);
    rd_chk("R1 year", 3'd6, 8'h00); rd_chk("R2 addr7", 3'd7, 8'h00);
  endtask

  task automatic t_regs;
    set_time(8'h13, 8'h27, 8'h45);
    set_date(8'h05, 8'h18, 8'h07, 8'h42);
    rd_chk("R2 hour", 3'd2, 8'h13); rd_chk("R2 min", 3'd1, 8'h27);
    rd_chk("R2 sec", 3'd0, 8'h45);  rd_chk("R2 dow", 3'd3, 8'h05);
    rd_chk("R2 date", 3'd4, 8'h18); rd_chk("R2 mon", 3'd5, 8'h07);
    rd_chk("R2 year", 3'd6, 8'h42);
    wr(3'd7, 8'hAA);
    rd_chk("R2 addr7 write", 3'd7, 8'h00);
    rd_chk("R2 sec kept", 3'd0, 8'h45);
    rd_chk("R3 idle year", 3'd6, 8'h42);
  endtask

  task automatic t_bcd_seconds;
    bin = 1'b0; h24 = 1'b1;
    set_time(8'h10, 8'h09, 8'h09);
    tick1; rd_chk("R3 bcd digit carry", 3'd0, 8'h10);
    rd_chk("R3 min untouched", 3'd1, 8'h09);
    wr(3'd0, 8'h59);
    tick1; rd_chk("R4 bcd sec wrap", 3'd0, 8'h00);
    rd_chk("R4 bcd min carry", 3'd1, 8'h10);
  endtask

  task automatic t_bin_seconds;
    bin = 1'b1; h24 = 1'b1;
    set_time(8'h00, 8'h05, 8'h3A);
    tick1; rd_chk("R4 bin sec 3B", 3'd0, 8'h3B);
    tick1; rd_chk("R4 bin sec wrap", 3'd0, 8'h00);
    rd_chk("R4 bin min", 3'd1, 8'h06);
    set_time(8'h02, 8'h3B, 8'h3B);
    tick1; rd_chk("R4 bin min wrap", 3'd1, 8'h00);
    rd_chk("R4 bin hour", 3'd2, 8'h03);
  endtask

  task automatic t_24h;
    bin = 1'b0; h24 = 1'b1;
    set_date(8'h03, 8'h14, 8'h05, 8'h21);
    set_time(8'h23, 8'h59, 8'h59);
    tick1;
    rd_chk("R5 hour wrap", 3'd2, 8'h00);
    rd_chk("R5 date carry", 3'd4, 8'h15);
    rd_chk("R7 dow step", 3'd3, 8'h04);
  endtask

  task automatic t_12h;
    bin = 1'b0; h24 = 1'b0;
    set_date(8'h07, 8'h10, 8'h03, 8'h21);
    set_time(8'h11, 8'h59, 8'h59);
    tick1; rd_chk("R6 11am to 12pm", 3'd2, 8'h92);
    rd_chk("R6 no day carry at noon", 3'd4, 8'h10);
    set_time(8'h92, 8'h59, 8'h59);
    tick1; rd_chk("R6 12pm to 1pm", 3'd2, 8'h81);
    set_time(8'h91, 8'h59, 8'h59);
    tick1; rd_chk("R6 11pm to 12am", 3'd2, 8'h12);
    rd_chk("R6 midnight date", 3'd4, 8'h11);
    rd_chk("R7 dow 7 to 1", 3'd3, 8'h01);
    bin = 1'b1;
    set_time(8'h0B, 8'h3B, 8'h3B);
    tick1; rd_chk("R6 bin 11am to 12pm", 3'd2, 8'h8C);
    h24 = 1'b1;
  endtask

  task automatic t_months;
    bin = 1'b0; h24 = 1'b1;
    set_date(8'h02, 8'h30, 8'h04, 8'h21);
    set_time(8'h23, 8'h59, 8'h59);
    tick1; rd_chk("R8 apr 30 date", 3'd4, 8'h01); rd_chk("R8 apr 30 mon", 3'd5, 8'h05);
    set_date(8'h02, 8'h30, 8'h05, 8'h21);
    set_time(8'h23, 8'h59, 8'h59);
    tick1; rd_chk("R8 may 31 exists", 3'd4, 8'h31); rd_chk("R8 may kept", 3'd5, 8'h05);
    bin = 1'b1;
    set_date(8'h02, 8'h1E, 8'h09, 8'h15);
    set_time(8'h17, 8'h3B, 8'h3B);
    tick1; rd_chk("R8 bin sep 30 date", 3'd4, 8'h01); rd_chk("R8 bin sep 30 mon", 3'd5, 8'h0A);
    bin = 1'b0;
  endtask

  task automatic t_leap;
    bin = 1'b0; h24 = 1'b1;
    set_date(8'h01, 8'h28, 8'h02, 8'h24);
    set_time(8'h23, 8'h59, 8'h59);
    tick1; rd_chk("R9 leap 29", 3'd4, 8'h29);
    set_time(8'h23, 8'h59, 8'h59);
    tick1; rd_chk("R9 leap to mar date", 3'd4, 8'h01); rd_chk("R9 leap to mar", 3'd5, 8'h03);
    set_date(8'h01, 8'h28, 8'h02, 8'h00);
    set_time(8'h23, 8'h59, 8'h59);
    tick1; rd_chk("R9 year 00 leap", 3'd4, 8'h29);
    set_date(8'h01, 8'h28, 8'h02, 8'h23);
    set_time(8'h23, 8'h59, 8'h59);
    tick1; rd_chk("R9 common year date", 3'd4, 8'h01); rd_chk("R9 common year mon", 3'd5, 8'h03);
    bin = 1'b1;
    set_date(8'h01, 8'h1C, 8'h02, 8'h18);
    set_time(8'h17, 8'h3B, 8'h3B);
    tick1; rd_chk("R9 bin leap 29", 3'd4, 8'h1D);
    bin = 1'b0;
  endtask

  task automatic t_year;
    bin = 1'b0; h24 = 1'b1;
    set_date(8'h04, 8'h31, 8'h12, 8'h99);
    set_time(8'h23, 8'h59, 8'h59);
    tick1;
    rd_chk("R10 date", 3'd4, 8'h01); rd_chk("R10 mon", 3'd5, 8'h01);
    rd_chk("R10 year 99 wrap", 3'd6, 8'h00);
    set_date(8'h04, 8'h31, 8'h12, 8'h19);
    set_time(8'h23, 8'h59, 8'h59);
    tick1; rd_chk("R10 year bcd carry", 3'd6, 8'h20);
  endtask

  task automatic t_hold;
    bin = 1'b0; h24 = 1'b1;
    set_time(8'h08, 8'h20, 8'h10);
    @(negedge clk); hold = 1'b1;
    tick1; tick1; tick1;
    rd_chk("R11 hold sec", 3'd0, 8'h10);
    wr(3'd1, 8'h33);
    rd_chk("R11 write under hold", 3'd1, 8'h33);
    @(negedge clk); hold = 1'b0;
    tick1; rd_chk("R11 resumes", 3'd0, 8'h11);
  endtask

  task automatic t_collide;
    set_time(8'h08, 8'h20, 8'h59);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd2; wdata = 8'h09; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd_chk("R12 written field", 3'd2, 8'h09);
    rd_chk("R12 sec not advanced", 3'd0, 8'h59);
    rd_chk("R12 min not advanced", 3'd1, 8'h20);
  endtask

  task automatic t_spring;
    bin = 1'b0; h24 = 1'b1; dst = 1'b1;
    set_date(8'h01, 8'h05, 8'h04, 8'h21);
    set_time(8'h01, 8'h59, 8'h59);
    tick1; rd_chk("R13 jump hour", 3'd2, 8'h03);
    rd_chk("R13 min zero", 3'd1, 8'h00);
    dst = 1'b0;
    set_time(8'h01, 8'h59, 8'h59);
    tick1; rd_chk("R13 disabled", 3'd2, 8'h02);
    dst = 1'b1;
    set_date(8'h01, 8'h12, 8'h04, 8'h21);
    set_time(8'h01, 8'h59, 8'h59);
    tick1; rd_chk("R13 second week no jump", 3'd2, 8'h02);
    h24 = 1'b0;
    set_date(8'h01, 8'h02, 8'h04, 8'h21);
    set_time(8'h01, 8'h59, 8'h59);
    tick1; rd_chk("R13 12h jump", 3'd2, 8'h03);
    h24 = 1'b1;
  endtask

  task automatic t_fall;
    bin = 1'b0; h24 = 1'b1; dst = 1'b1;
    set_date(8'h01, 8'h27, 8'h10, 8'h21);
    set_time(8'h01, 8'h59, 8'h59);
    tick1; rd_chk("R14 fall back hour", 3'd2, 8'h01);
    rd_chk("R14 fall back min", 3'd1, 8'h00);
    set_time(8'h01, 8'h59, 8'h59);
    tick1; rd_chk("R14 only once", 3'd2, 8'h02);
    dst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_bcd_seconds;
    t_bin_seconds;
    t_24h;
    t_12h;
    t_months;
    t_leap;
    t_year;
    t_hold;
    t_collide;
    t_spring;
    t_fall;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule